// File: doc/BRIEF.md
# DMA Transfer Mode Sequencer

This block is a single-channel DMA sequencer. It moves bytes between a peripheral and memory without help from the processor. When the peripheral raises its request, the sequencer asks the processor for the system bus through a hold request and waits for the hold acknowledge. It then runs each byte through a fixed three-phase cycle: address out, read strobe, write strobe. After each byte the memory address steps up by one and the remaining count steps down by one. The acknowledge to the peripheral is high during all three phases. On the last byte a terminal-count output marks the end of the operation.

The transfer mode decides when the bus goes back to the processor:

- **Single mode** releases the bus after every byte.
- **Demand mode** keeps the bus while the peripheral keeps requesting. A paused demand transfer resumes later from its saved address and count.
- **Block mode** keeps the bus until the whole programmed count is done, whatever the peripheral request does.

Mode, start address and byte count are loaded through a small register write port. A separate write arms the channel.

Top module: `dma_mode_seq`

## Requirements
- R1: After a synchronous active-low reset, the following outputs are all low or zero: `hold_req`, `dack`, `addr_oe`, `rd_stb`, `wr_stb`, `tc`, `mem_addr` and `cnt_left`.
- R2: A write with `cfg_we` high takes effect on the next clock. The field loaded depends on `cfg_sel`:
  - `cfg_sel` 0 loads the mode from `cfg_wdata[1:0]`: 0 is single, 1 is demand, 2 is block, and 3 acts as single.
  - `cfg_sel` 1 loads the start address, which then shows on `mem_addr`.
  - `cfg_sel` 2 loads the byte count, which then shows on `cnt_left`.
- R3: A write with `cfg_sel` 3 arms the channel only when `cnt_left` is nonzero. With a zero count the arm write has no effect, and `hold_req` stays low whatever `dreq` does.
- R4: An armed channel that samples `dreq` high raises `hold_req` on the next cycle. The first address phase follows the cycle in which `hlda` is sampled high. No phase occurs before that. `dack` is only ever high while `hold_req` is high.
- R5: Each byte takes three cycles in this order: `addr_oe`, `rd_stb`, `wr_stb`. Exactly one of these is high in each of those cycles, and `dack` is high in all three. On the cycle after `wr_stb`, `mem_addr` has risen by 1 and `cnt_left` has fallen by 1.
- R6: In single mode, `hold_req` is low on the cycle after every write phase. The next byte needs a fresh request and a fresh hold handshake.
- R7: In demand mode, the sequencer handles a write phase according to `dreq` sampled during it:
  - If `dreq` is low, `hold_req` drops on the next cycle.
  - If `dreq` is high, the next address phase follows at once.
  - A later request resumes from the unchanged address and count.
- R8: In block mode, the cycle after each write phase that is not the last is an address phase, whatever `dreq` does.
- R9: `tc` is high during all three phases of the byte transferred while `cnt_left` is 1, in every mode. After that byte, `hold_req` drops, `cnt_left` is 0, and the channel stays disarmed even with `dreq` high.
- R10: Configuration writes of any kind are ignored while the channel is armed or transferring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration field select (0 mode, 1 address, 2 count, 3 arm) |
| cfg_wdata | input | CFG_W | Configuration write data |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Acknowledge to the peripheral during a byte transfer |
| hold_req | output | 1 | Bus request to the processor |
| hlda | input | 1 | Bus grant from the processor |
| mem_addr | output | ADDR_W | Current memory address |
| cnt_left | output | CNT_W | Bytes still to transfer |
| addr_oe | output | 1 | Address phase |
| rd_stb | output | 1 | Read strobe phase |
| wr_stb | output | 1 | Write strobe phase |
| tc | output | 1 | Terminal count, high during the last byte |

## Verification
All outputs come straight from registers, so each result is due a fixed number of edges after the input that causes it:

- A configuration write shows one clock later.
- `hold_req` rises one clock after `dreq` is sampled while the channel is armed.
- The address phase starts one clock after `hlda` is sampled high.
- The counters and the release of `hold_req` land one clock after the write phase.

The bench drives inputs on the falling edge. A behavioural model updates on the rising edge, and every output is compared with it on the next falling edge. Directed checks wait for `wr_stb` and then sample exactly one falling edge later, where each mode's release or continuation must be visible.

// File: rtl/dma_seq_pkg.sv
// Package: shared types for the DMA mode sequencer.
// Assumes: nothing; holds only types and field codes.
package dma_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_DEMAND = 2'd1,
        MODE_BLOCK  = 2'd2,
        MODE_ALT    = 2'd3
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_HOLD  = 3'd2,
        ST_ADDR  = 3'd3,
        ST_READ  = 3'd4,
        ST_WRITE = 3'd5
    } seq_state_e;

    localparam logic [1:0] SEL_MODE  = 2'd0;
    localparam logic [1:0] SEL_ADDR  = 2'd1;
    localparam logic [1:0] SEL_COUNT = 2'd2;
    localparam logic [1:0] SEL_ARM   = 2'd3;

endpackage

// File: rtl/dma_cfg_regs.sv
// Module: configuration write decoder and mode register.
// Decodes the write port into a mode update, load strobes for the address
// and count counters, and an arm pulse. It assumes the sequencer reports
// idle; every write arriving while not idle is dropped here.
module dma_cfg_regs
    import dma_seq_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [CFG_W-1:0] wdata,
    input  logic             idle,
    output xfer_mode_e       mode,
    output logic             ld_addr,
    output logic             ld_cnt,
    output logic             arm,
    output logic [CFG_W-1:0] ld_val
);

    logic wr_ok;

    // Accept writes only while the channel is idle.
    always_comb begin
        wr_ok   = we && idle;
        ld_addr = wr_ok && (sel == SEL_ADDR);
        ld_cnt  = wr_ok && (sel == SEL_COUNT);
        arm     = wr_ok && (sel == SEL_ARM);
        ld_val  = wdata;
    end

    // Mode register, updated by an accepted mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_SINGLE;
        end else if (wr_ok && (sel == SEL_MODE)) begin
            mode <= xfer_mode_e'(wdata[1:0]);
        end
    end

    AST_CFG_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(mode)) else $error("mode changed while busy"); // R10

endmodule

// File: rtl/dma_step_ctr.sv
// Module: loadable counter stepping by one in a fixed direction.
// COUNT_UP selects increment (address) or decrement (byte count).
// Assumes: load and step are never needed in the same cycle; load wins.
module dma_step_ctr #(
    parameter int W        = 16,
    parameter bit COUNT_UP = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] q_step;

    generate
        if (COUNT_UP) begin : g_up
            // Next value when counting upward.
            assign q_step = q + ONE;
        end else begin : g_down
            // Next value when counting downward.
            assign q_step = q - ONE;
        end
    endgenerate

    // Counter register with load priority over step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (step) begin
            q <= q_step;
        end
    end

    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(q)) else $error("counter drifted"); // R5

endmodule

// File: rtl/dma_bus_fsm.sv
// Module: bus handshake and transfer phase sequencer.
// Runs idle, armed, hold-wait and the three per-byte phases. The mode
// decides where a write phase leads. Assumes hlda, once granted, stays
// high while hold_req is high.
module dma_bus_fsm
    import dma_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xfer_mode_e       mode,
    input  logic             arm,
    input  logic [CNT_W-1:0] cnt,
    input  logic             dreq,
    input  logic             hlda,
    output logic             hold_req,
    output logic             dack,
    output logic             addr_oe,
    output logic             rd_stb,
    output logic             wr_stb,
    output logic             tc,
    output logic             step,
    output logic             idle
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    seq_state_e state, nxt;
    logic       cnt_zero;
    logic       cnt_last;

    // Count status used for arming and for ending the operation.
    always_comb begin
        cnt_zero = (cnt == '0);
        cnt_last = (cnt == CNT_ONE);
    end

    // Next-state selection, including the mode-dependent release point.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (arm && !cnt_zero) nxt = ST_ARMED;
            ST_ARMED: if (dreq) nxt = ST_HOLD;
            ST_HOLD:  if (hlda) nxt = ST_ADDR;
            ST_ADDR:  nxt = ST_READ;
            ST_READ:  nxt = ST_WRITE;
            ST_WRITE: begin
                if (cnt_last) begin
                    nxt = ST_IDLE;
                end else begin
                    case (mode)
                        MODE_DEMAND: nxt = dreq ? ST_ADDR : ST_ARMED;
                        MODE_BLOCK:  nxt = ST_ADDR;
                        default:     nxt = ST_ARMED;
                    endcase
                end
            end
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Outputs decoded from the registered state only.
    always_comb begin
        addr_oe  = (state == ST_ADDR);
        rd_stb   = (state == ST_READ);
        wr_stb   = (state == ST_WRITE);
        dack     = addr_oe || rd_stb || wr_stb;
        hold_req = dack || (state == ST_HOLD);
        tc       = dack && cnt_last;
        step     = wr_stb;
        idle     = (state == ST_IDLE);
    end

    AST_DACK_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dack |-> hold_req) else $error("dack without bus"); // R4
    AST_WAIT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req && !dack && !hlda) |=> !addr_oe) else $error("phase before grant"); // R4
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_oe, rd_stb, wr_stb})) else $error("phase overlap"); // R5
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> wr_stb) else $error("write phase missing"); // R5
    AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (mode == MODE_SINGLE)) |=> !hold_req) else $error("single kept bus"); // R6
    AST_DEMAND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (mode == MODE_DEMAND) && !dreq) |=> !hold_req) else $error("demand kept bus"); // R7
    AST_BLOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (mode == MODE_BLOCK) && !tc) |=> addr_oe) else $error("block paused"); // R8
    AST_TC_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && tc) |=> (idle && !hold_req)) else $error("no end after tc"); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !cnt_zero) else $error("count underflow"); // R9

endmodule

// File: rtl/dma_mode_seq.sv
// Module: top of the single-channel DMA mode sequencer.
// Joins the configuration decoder, the address and byte counters, and the
// bus sequencer. Assumes ADDR_W and CNT_W do not exceed CFG_W.
module dma_mode_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              dreq,
    output logic              dack,
    output logic              hold_req,
    input  logic              hlda,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CNT_W-1:0]  cnt_left,
    output logic              addr_oe,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              tc
);

    xfer_mode_e       mode;
    logic             ld_addr, ld_cnt, arm, step, idle;
    logic [CFG_W-1:0] ld_val;

    dma_cfg_regs #(.CFG_W(CFG_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .idle(idle), .mode(mode),
        .ld_addr(ld_addr), .ld_cnt(ld_cnt), .arm(arm), .ld_val(ld_val)
    );

    dma_step_ctr #(.W(ADDR_W), .COUNT_UP(1'b1)) i_addr_ctr (
        .clk(clk), .rst_n(rst_n), .load(ld_addr),
        .load_val(ld_val[ADDR_W-1:0]), .step(step), .q(mem_addr)
    );

    dma_step_ctr #(.W(CNT_W), .COUNT_UP(1'b0)) i_cnt_ctr (
        .clk(clk), .rst_n(rst_n), .load(ld_cnt),
        .load_val(ld_val[CNT_W-1:0]), .step(step), .q(cnt_left)
    );

    dma_bus_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .mode(mode), .arm(arm), .cnt(cnt_left),
        .dreq(dreq), .hlda(hlda), .hold_req(hold_req), .dack(dack),
        .addr_oe(addr_oe), .rd_stb(rd_stb), .wr_stb(wr_stb), .tc(tc),
        .step(step), .idle(idle)
    );

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (mem_addr == $past(mem_addr) + ADDR_W'(1))) else $error("address not stepped"); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (cnt_left == $past(cnt_left) - CNT_W'(1))) else $error("count not stepped"); // R5

endmodule

// File: tb/test_dma_mode_seq.sv
module test_dma_mode_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        dreq = 1'b0;
    logic        hlda = 1'b0;
    logic        dack, hold_req, addr_oe, rd_stb, wr_stb, tc;
    logic [15:0] mem_addr, cnt_left;

    int checks = 0;
    int errors = 0;
    int lat = 1;
    int hcnt = 0;
    bit cmp_en = 1'b0;

    // Behavioural reference: phase 0 idle, 1 armed, 2 hold wait, 3 address, 4 read, 5 write.
    int m_ph = 0, m_mode = 0, m_addr = 0, m_cnt = 0;

    always #2.5 clk = ~clk;

    dma_mode_seq i_dma_mode_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dreq(dreq), .dack(dack), .hold_req(hold_req),
        .hlda(hlda), .mem_addr(mem_addr), .cnt_left(cnt_left),
        .addr_oe(addr_oe), .rd_stb(rd_stb), .wr_stb(wr_stb), .tc(tc)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        int nx;
        if (!rst_n) begin
            m_ph = 0; m_mode = 0; m_addr = 0; m_cnt = 0;
        end else begin
            nx = m_ph;
            case (m_ph)
                0: if (cfg_we) begin
                    if (cfg_sel == 2'd0) m_mode = int'(cfg_wdata[1:0]);
                    else if (cfg_sel == 2'd1) m_addr = int'(cfg_wdata);
                    else if (cfg_sel == 2'd2) m_cnt = int'(cfg_wdata);
                    else if (m_cnt != 0) nx = 1;
                end
                1: if (dreq) nx = 2;
                2: if (hlda) nx = 3;
                3: nx = 4;
                4: nx = 5;
                default: begin
                    if (m_cnt == 1) nx = 0;
                    else if (m_mode == 1) nx = dreq ? 3 : 1;
                    else if (m_mode == 2) nx = 3;
                    else nx = 1;
                    m_addr = (m_addr + 1) & 16'hFFFF;
                    m_cnt = m_cnt - 1;
                end
            endcase
            m_ph = nx;
        end
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            cmp("R4", "hold_req", int'(hold_req), int'(m_ph >= 2));
            cmp("R5", "dack",     int'(dack),     int'(m_ph >= 3));
            cmp("R5", "addr_oe",  int'(addr_oe),  int'(m_ph == 3));
            cmp("R5", "rd_stb",   int'(rd_stb),   int'(m_ph == 4));
            cmp("R5", "wr_stb",   int'(wr_stb),   int'(m_ph == 5));
            cmp("R9", "tc",       int'(tc),       int'(m_ph >= 3 && m_cnt == 1));
            cmp("R5", "mem_addr", int'(mem_addr), m_addr);
            cmp("R5", "cnt_left", int'(cnt_left), m_cnt);
        end
    end

    // Processor side: grant the bus lat cycles after seeing the request.
    initial begin
        forever begin
            @(negedge clk);
            if (hold_req) hcnt++; else hcnt = 0;
            hlda = hold_req && (hcnt >= lat);
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (all requirements)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic cfg_write(input logic [1:0] s, input logic [15:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_wr();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!wr_stb && n < 200);
    endtask

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        cmp("R1", "hold_req", int'(hold_req), 0);
        cmp("R1", "strobes", int'({dack, addr_oe, rd_stb, wr_stb, tc}), 0);
        cmp("R1", "mem_addr", int'(mem_addr), 0);
        cmp("R1", "cnt_left", int'(cnt_left), 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);

        // Single mode, two bytes, request held high throughout.
        cfg_write(2'd0, 16'd0);
        cfg_write(2'd1, 16'h0100);
        cfg_write(2'd2, 16'd2);
        cmp("R2", "mem_addr load", int'(mem_addr), 16'h0100);
        cmp("R2", "cnt_left load", int'(cnt_left), 2);
        cfg_write(2'd3, 16'd0);
        dreq = 1'b1;
        wait_wr();
        cmp("R9", "tc on first byte", int'(tc), 0);
        @(negedge clk);
        cmp("R6", "released after byte", int'(hold_req), 0);
        cmp("R5", "address stepped", int'(mem_addr), 16'h0101);
        cmp("R5", "count stepped", int'(cnt_left), 1);
        wait_wr();
        cmp("R9", "tc on last byte", int'(tc), 1);
        @(negedge clk);
        cmp("R9", "released at end", int'(hold_req), 0);
        repeat (4) @(negedge clk);
        cmp("R9", "stays disarmed", int'(hold_req), 0);
        dreq = 1'b0;

        // Demand mode with a pause and a resume.
        cfg_write(2'd0, 16'd1);
        cfg_write(2'd1, 16'h0200);
        cfg_write(2'd2, 16'd4);
        cfg_write(2'd3, 16'd0);
        dreq = 1'b1;
        wait_wr();
        dreq = 1'b0;
        @(negedge clk);
        cmp("R7", "released on request drop", int'(hold_req), 0);
        cfg_write(2'd1, 16'h0999);
        cfg_write(2'd2, 16'd9);
        @(negedge clk);
        cmp("R10", "address write ignored", int'(mem_addr), 16'h0201);
        cmp("R10", "count write ignored", int'(cnt_left), 3);
        dreq = 1'b1;
        wait_wr();
        @(negedge clk);
        cmp("R7", "back-to-back while requested", int'(addr_oe), 1);
        wait_wr();
        wait_wr();
        cmp("R9", "tc in demand", int'(tc), 1);
        @(negedge clk);
        cmp("R9", "demand ends at count", int'(hold_req), 0);
        cmp("R7", "resumed address", int'(mem_addr), 16'h0204);
        dreq = 1'b0;

        // Block mode, request only pulsed.
        cfg_write(2'd0, 16'd2);
        cfg_write(2'd1, 16'h0300);
        cfg_write(2'd2, 16'd3);
        cfg_write(2'd3, 16'd0);
        dreq = 1'b1;
        @(negedge clk);
        dreq = 1'b0;
        wait_wr();
        @(negedge clk);
        cmp("R8", "block continues", int'(addr_oe), 1);
        wait_wr();
        @(negedge clk);
        cmp("R8", "block continues again", int'(addr_oe), 1);
        wait_wr();
        cmp("R9", "tc in block", int'(tc), 1);
        @(negedge clk);
        cmp("R9", "block released", int'(hold_req), 0);
        cmp("R8", "block end address", int'(mem_addr), 16'h0303);

        // Slow grant: phases wait for hold acknowledge.
        lat = 3;
        cfg_write(2'd0, 16'd0);
        cfg_write(2'd1, 16'h0400);
        cfg_write(2'd2, 16'd1);
        cfg_write(2'd3, 16'd0);
        dreq = 1'b1;
        begin
            int n = 0;
            while (!hold_req && n < 50) begin @(negedge clk); n++; end
            n = 0;
            while (!addr_oe && n < 50) begin @(negedge clk); n++; end
            cmp("R4", "grant to address delay", n, 3);
        end
        wait_wr();
        dreq = 1'b0;
        lat = 1;
        @(negedge clk);

        // Arm with zero count is ignored.
        cfg_write(2'd2, 16'd0);
        cfg_write(2'd3, 16'd0);
        dreq = 1'b1;
        repeat (5) @(negedge clk);
        cmp("R3", "zero count not armed", int'(hold_req), 0);
        dreq = 1'b0;

        // Mode code 3 behaves as single.
        cfg_write(2'd0, 16'd3);
        cfg_write(2'd2, 16'd2);
        cfg_write(2'd3, 16'd0);
        dreq = 1'b1;
        wait_wr();
        @(negedge clk);
        cmp("R2", "mode 3 releases per byte", int'(hold_req), 0);
        wait_wr();
        dreq = 1'b0;
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule